// File: doc/BRIEF.md
# Range-Switched Decimal Frequency Counter

This block measures how often a digital input rises and reports the result as four packed BCD decimal digits. A reference clock of `CLK_HZ` cycles per second sets the length of a gate window, and a two-bit selector chooses how long that window is. Rising edges of the input are synchronized and then counted inside the window by a chain of decade counters. At the end of each window the block stores the digits, a decimal-point marker and an overflow flag in output registers, and it pulses a valid strobe.

A window of one second gives a reading in hertz with the point after the top digit (up to 9.999 kHz). A window of one tenth of a second moves the point one digit lower (up to 99.99 kHz). A window of one hundredth of a second moves it lower again (up to 999.9 kHz). A display stage downstream reads the digits and the point marker and shows the value in kHz. If the count needs a fifth decade, the block reports an overflow instead of a number.

Top module: `freq_meter_bcd`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `bcd_o`, `dp_o`, `ovf_o` and `valid_o` are all zero.
- R2: With `range_sel` = 2'b00 the gate window lasts `CLK_HZ` clock cycles. Results arrive every `CLK_HZ`+2 cycles, and `dp_o` = 4'b1000 (point after the most significant digit).
- R3: With `range_sel` = 2'b01 the window lasts `CLK_HZ`/10 cycles. Results arrive every `CLK_HZ`/10+2 cycles, and `dp_o` = 4'b0100.
- R4: With `range_sel` = 2'b10 or 2'b11 the window lasts `CLK_HZ`/100 cycles. Results arrive every `CLK_HZ`/100+2 cycles, and `dp_o` = 4'b0010.
- R5: When there is no overflow, `bcd_o` holds the number of input rising edges seen in the window. It is written as four 8421 BCD digits, with the most significant digit in bits [15:12] and the least significant in bits [3:0].
- R6: If a window sees 10000 or more rising edges, the result has `ovf_o` = 1 and `bcd_o` = 16'hFFFF. The flag belongs only to that window, so the next result with fewer edges has `ovf_o` = 0.
- R7: `valid_o` is high for exactly one cycle for each new result. `bcd_o`, `dp_o` and `ovf_o` change only on that cycle and hold their values at all other times.
- R8: A change of `range_sel` abandons the window in progress. No result is produced for that window, and the outputs keep their last values. The next result comes one full window of the new range later and counts only edges that arrive after the change.
- R9: The input passes through a two-stage synchronizer. Only low-to-high transitions are counted, so an input that stays high across windows adds one to the first window and nothing to the later ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, `CLK_HZ` cycles per second |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 1 | Signal to be measured, asynchronous |
| range_sel | input | 2 | Range select: 00 = 10 kHz, 01 = 100 kHz, 1x = 1 MHz |
| bcd_o | output | 16 | Latched reading, four packed BCD digits |
| dp_o | output | 4 | One-hot decimal-point marker; bit i means the point follows digit i |
| ovf_o | output | 1 | Latched overflow flag for the reading |
| valid_o | output | 1 | One-cycle strobe when a new reading is latched |

## Verification
The output registers load only on the latch cycle, so any wrong internal state shows up within one window. A decade that carries at the wrong point, or a counter that is not cleared, gives wrong digits on the very next strobe. A gate timer loaded for the wrong range shows up as a wrong interval between strobes or a wrong point marker. An abort that is missed shows up as a strobe arriving too early or too late after a range change, or as counts carried over from before the change. The edge counts and the intervals between strobes are therefore both checked exactly against the number of pulses the bench applied.

// File: rtl/fm_pkg.sv
package fm_pkg;

  typedef enum logic [1:0] {
    ST_COUNT = 2'd0,
    ST_LATCH = 2'd1,
    ST_CLEAR = 2'd2
  } fm_state_e;

  // Map the range selector to a scale index: 0 = longest window.
  function automatic int unsigned scale_idx(input logic [1:0] sel);
    case (sel)
      2'b00:   return 0;
      2'b01:   return 1;
      default: return 2;
    endcase
  endfunction

endpackage

// File: rtl/fm_edge_sync.sv
module fm_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);

  // STAGES synchronizer flops plus one history flop for edge detection.
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-1:0], din};
  end

  assign rise = pipe[STAGES-1] & ~pipe[STAGES];

endmodule

// File: rtl/fm_gate_timer.sv
module fm_gate_timer #(
  parameter int unsigned CLK_HZ = 50_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic       run,
  input  logic [1:0] scale_sel,
  output logic       last
);

  localparam int unsigned WIN0 = CLK_HZ;
  localparam int unsigned WIN1 = CLK_HZ / 10;
  localparam int unsigned WIN2 = CLK_HZ / 100;
  localparam int unsigned CW   = $clog2(WIN0 + 1);

  logic [CW-1:0] tick;
  logic [CW-1:0] limit;

  always_comb begin
    case (fm_pkg::scale_idx(scale_sel))
      0:       limit = CW'(WIN0 - 1);
      1:       limit = CW'(WIN1 - 1);
      default: limit = CW'(WIN2 - 1);
    endcase
  end

  assign last = run && (tick == limit);

  always_ff @(posedge clk) begin
    if (rst || restart || last) tick <= '0;
    else if (run)               tick <= tick + 1'b1;
  end

endmodule

// File: rtl/fm_bcd_digit.sv
module fm_bcd_digit (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       inc,
  output logic [3:0] digit,
  output logic       carry
);

  assign carry = inc && (digit == 4'd9);

  always_ff @(posedge clk) begin
    if (rst || clr) digit <= 4'd0;
    else if (inc)   digit <= (digit == 4'd9) ? 4'd0 : digit + 4'd1;
  end

endmodule

// File: rtl/freq_meter_bcd.sv
module freq_meter_bcd
  import fm_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned DIGITS      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sig_in,
  input  logic [1:0]            range_sel,
  output logic [4*DIGITS-1:0]   bcd_o,
  output logic [DIGITS-1:0]     dp_o,
  output logic                  ovf_o,
  output logic                  valid_o
);

  localparam int unsigned BW = 4 * DIGITS;

  fm_state_e         state;
  logic [1:0]        range_q;
  logic              range_chg;
  logic              rise;
  logic              win_last;
  logic              cnt_en;
  logic              cnt_clr;
  logic              latch_now;
  logic              ovf_sticky;
  logic [BW-1:0]     digits;
  logic [DIGITS-1:0] carry;
  logic [DIGITS:0]   inc;

  assign range_chg = (range_sel != range_q);
  assign cnt_en    = (state == ST_COUNT) && rise && !range_chg;
  assign cnt_clr   = (state == ST_CLEAR);
  assign latch_now = (state == ST_LATCH) && !range_chg;

  fm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (sig_in),
    .rise (rise)
  );

  fm_gate_timer #(.CLK_HZ(CLK_HZ)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .restart   (cnt_clr),
    .run       ((state == ST_COUNT) && !range_chg),
    .scale_sel (range_q),
    .last      (win_last)
  );

  // Decade chain: each digit increments on the carry of the one below it.
  assign inc[0] = cnt_en;
  for (genvar gi = 0; gi < DIGITS; gi++) begin : g_dec
    fm_bcd_digit u_dig (
      .clk   (clk),
      .rst   (rst),
      .clr   (cnt_clr),
      .inc   (inc[gi]),
      .digit (digits[4*gi +: 4]),
      .carry (carry[gi])
    );
    assign inc[gi+1] = carry[gi];
  end

  // The carry out of the top decade leaves the chain here.
  logic top_carry;
  assign top_carry = inc[DIGITS];

  function automatic logic [DIGITS-1:0] dp_code(input logic [1:0] sel);
    logic [DIGITS-1:0] v;
    v = '0;
    v[DIGITS - 1 - scale_idx(sel)] = 1'b1;
    return v;
  endfunction

  // Sequencer: count window, one latch cycle, one clear cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_COUNT;
      range_q <= 2'b00;
    end else if (range_chg) begin
      range_q <= range_sel;
      state   <= ST_CLEAR;
    end else begin
      case (state)
        ST_COUNT: if (win_last) state <= ST_LATCH;
        ST_LATCH: state <= ST_CLEAR;
        default:  state <= ST_COUNT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || cnt_clr) ovf_sticky <= 1'b0;
    else if (top_carry) ovf_sticky <= 1'b1;
  end

  // Result registers.
  always_ff @(posedge clk) begin
    if (rst) begin
      bcd_o   <= '0;
      dp_o    <= '0;
      ovf_o   <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= latch_now;
      if (latch_now) begin
        bcd_o <= ovf_sticky ? {BW{1'b1}} : digits;
        dp_o  <= dp_code(range_q);
        ovf_o <= ovf_sticky;
      end
    end
  end

endmodule

// File: rtl/fm_checker.sv
module fm_checker #(
  parameter int unsigned DIGITS = 4
) (
  input logic                clk,
  input logic                rst,
  input logic [1:0]          range_sel,
  input logic [4*DIGITS-1:0] bcd_o,
  input logic [DIGITS-1:0]   dp_o,
  input logic                ovf_o,
  input logic                valid_o
);

  logic all_decimal;
  always_comb begin
    all_decimal = 1'b1;
    for (int i = 0; i < DIGITS; i++)
      if (bcd_o[4*i +: 4] > 4'd9) all_decimal = 1'b0;
  end

  // R7
  valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> ($stable(bcd_o) && $stable(dp_o) && $stable(ovf_o)));

  // R6
  ovf_code_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_o |-> (bcd_o == {4*DIGITS{1'b1}}));

  // R5
  bcd_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !ovf_o) |-> all_decimal);

  // R8
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    (range_sel != $past(range_sel)) |=> !valid_o);

  // R2
  dp_single_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> ($countones(dp_o) == 1));

endmodule

bind freq_meter_bcd fm_checker #(.DIGITS(DIGITS)) u_fm_chk (
  .clk       (clk),
  .rst       (rst),
  .range_sel (range_sel),
  .bcd_o     (bcd_o),
  .dp_o      (dp_o),
  .ovf_o     (ovf_o),
  .valid_o   (valid_o)
);

// File: tb/tb_freq_meter_bcd.sv
module tb_freq_meter_bcd;

  localparam int unsigned HZ = 24000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sig_in = 1'b0;
  logic [1:0]  range_sel = 2'b10;
  logic [15:0] bcd_o;
  logic [3:0]  dp_o;
  logic        ovf_o;
  logic        valid_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int last_v = 0;
  int gap = 0;
  logic [15:0] held;

  freq_meter_bcd #(.CLK_HZ(HZ)) dut (
    .clk(clk), .rst(rst), .sig_in(sig_in), .range_sel(range_sel),
    .bcd_o(bcd_o), .dp_o(dp_o), .ovf_o(ovf_o), .valid_o(valid_o)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] to_bcd(input int n);
    return {4'(n / 1000 % 10), 4'(n / 100 % 10), 4'(n / 10 % 10), 4'(n % 10)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_valid();
    do @(negedge clk); while (!valid_o);
    gap = cyc - last_v;
    last_v = cyc;
  endtask

  task automatic pulses(input int k);
    for (int i = 0; i < k; i++) begin
      sig_in = 1'b1; @(negedge clk);
      sig_in = 1'b0; @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (4) @(negedge clk);
    chk("R1 bcd", bcd_o, 0); chk("R1 dp", dp_o, 0);
    chk("R1 ovf", ovf_o, 0); chk("R1 valid", valid_o, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after", {bcd_o, dp_o, ovf_o, valid_o}, 0);

    // R4/R5 sweep of short window, range 10
    wait_valid();
    for (int k = 0; k <= 115; k++) begin
      pulses(k);
      wait_valid();
      chk("R5 count r2", bcd_o, to_bcd(k));
      chk("R4 dp", dp_o, 4'b0010);
      chk("R6 no ovf", ovf_o, 0);
      if (k > 0) chk("R4 period", gap, HZ / 100 + 2);
    end

    // R4 encoding 11 with R8 hold after change
    held = bcd_o;
    range_sel = 2'b11;
    pulses(37);
    chk("R8 no strobe", valid_o, 0);
    chk("R8 hold", bcd_o, held);
    wait_valid();
    chk("R4 sel11 count", bcd_o, to_bcd(37));
    chk("R4 sel11 dp", dp_o, 4'b0010);

    // R3 range 01
    range_sel = 2'b01;
    begin
      int vals[9] = '{0, 1, 9, 10, 99, 100, 999, 1000, 1099};
      for (int j = 0; j < 9; j++) begin
        pulses(vals[j]);
        wait_valid();
        chk("R5 count r1", bcd_o, to_bcd(vals[j]));
        chk("R3 dp", dp_o, 4'b0100);
        if (j > 0) chk("R3 period", gap, HZ / 10 + 2);
      end
    end

    // R9 level held high counts once
    sig_in = 1'b1;
    wait_valid();
    chk("R9 first", bcd_o, to_bcd(1));
    wait_valid();
    chk("R9 held", bcd_o, to_bcd(0));
    sig_in = 1'b0;
    wait_valid();
    chk("R9 fall", bcd_o, to_bcd(0));

    // R2 long window and R6 overflow
    range_sel = 2'b00;
    pulses(9999);
    wait_valid();
    chk("R2 max", bcd_o, to_bcd(9999));
    chk("R2 dp", dp_o, 4'b1000);
    chk("R6 below", ovf_o, 0);
    pulses(10000);
    wait_valid();
    chk("R2 period", gap, HZ + 2);
    chk("R6 ovf", ovf_o, 1);
    chk("R6 code", bcd_o, 16'hFFFF);
    pulses(3);
    wait_valid();
    chk("R6 cleared", ovf_o, 0);
    chk("R6 next", bcd_o, to_bcd(3));

    // R8 abort mid-window
    pulses(50);
    range_sel = 2'b10;
    gap = cyc; last_v = cyc;
    pulses(7);
    chk("R8 no strobe", valid_o, 0);
    chk("R8 hold", bcd_o, to_bcd(3));
    wait_valid();
    chk("R8 fresh window", (gap >= HZ / 100) && (gap <= HZ / 100 + 4), 1);
    chk("R8 count", bcd_o, to_bcd(7));
    chk("R8 dp", dp_o, 4'b0010);

    summary();
    $finish;
  end

endmodule